// File: doc/BRIEF.md
# PTP Nanosecond Time Counter with Fractional Rate Control

This block keeps precision network time as a 44-bit count of nanoseconds. It runs from a 125 MHz reference clock. Underneath the count sits a 28-bit fractional accumulator. On every reference cycle a programmable increment is added. The increment is expressed in units of 2^-28 ns, so the value 0x80000000 advances time by exactly 8 ns per cycle. Trimming it by 2^28 / 125e6 per part-per-billion steers the clock frequency. The count wraps to zero after 2^44 ns, which is roughly 4.9 hours.

Software reaches the counter through a small 32-bit register bus with four word registers. The increment register sits at offset 0x0C. The time is split into three fields: the bottom 4 ns bits at 0x00, bits [35:4] at 0x04, and the top byte at 0x08. The top byte reads back in data bits [7:0] but is written through data bits [15:8].

Setting the increment to zero stops the clock. Software can then load a new time without racing the count, and a nonzero increment starts it again. Reading the top byte snapshots the lower two fields, so a read of the top byte followed by a read of the middle field yields one coherent time even while the clock runs.

Top module: `nco_time_counter`

## Requirements
- R1: After reset the increment register reads 0x80000000, and no read response is pending (read-valid low, read data zero).
- R2: While the increment is zero and no time field is written, the nanosecond time stays unchanged.
- R3: A write to offset 0x08 loads time bits [43:36] from write-data bits [15:8] and ignores the other data bits. A read of offset 0x08 returns those time bits in read-data bits [7:0], with zeros above.
- R4: With the nominal increment 0x80000000, time advances by exactly 8 ns on every reference cycle.
- R5: The time wraps modulo 2^44 ns; the carry out of the top bit is discarded.
- R6: Increments with nonzero fractional bits accumulate exactly. For example, 0x08000000 adds 0.5 ns per cycle, so five cycles add 2 ns and leave half a nanosecond in the fraction.
- R7: A write to offset 0x00 loads time bits [3:0] from write-data bits [3:0] and clears the 28 fractional bits.
- R8: Reading offset 0x08 captures time bits [35:0]. Until offset 0x04 is next read, reads of 0x00 return the captured bits [3:0], and the next read of 0x04 returns the captured bits [35:4]. That read of 0x04 ends the capture.
- R9: A time-field write in a cycle replaces that cycle's accumulate. The written field takes the new value, and the other fields keep their values without the increment being added.
- R10: Offset 0x04 reads and writes time bits [35:4] as a full word. Offset 0x0C reads back the full 32-bit increment as written. Writing zero to all four registers leaves every register reading zero.
- R11: Each read request yields exactly one read response, with read-valid and data registered one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz reference clock; the time advances on each rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write request for this cycle |
| busRdEn | input | 1 | Register read request for this cycle |
| busAddr | input | 4 | Byte offset of the register (0x00, 0x04, 0x08, 0x0C) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Pulses one cycle after each read request |

## Verification
The bench targets the places where a counter like this typically goes wrong.

- **Split top-byte lanes (R3).** The bench writes the top byte with distinctive garbage in the read lane. A design that took the write from bits [7:0] would load 0x5A instead of the intended byte.
- **Wrap at 2^44 ns (R5).** The bench runs the count across the boundary. A wider or saturating counter would not come back to 16 ns.
- **Exact cycle counts.** Stepped runs and the R9 test pin down cycle-exact behaviour. A design that also accumulated in the cycle of a time write would come out 8 ns late.
- **Fraction clearing (R7).** A design that kept a stale half nanosecond after a low-field write would tick over one nanosecond early.
- **Coherent reads (R8).** The bench reads the middle field several cycles after the top byte while time runs. A design without the snapshot returns a later, torn value.

// File: rtl/nco_time_pkg.sv
package nco_time_pkg;

  localparam int BUS_W     = 32;
  localparam int LOW_W     = 4;
  localparam int MID_W     = 32;
  localparam int UP_LANE   = 8;   // write lane of the top byte starts at bit 8

  // word index of each register (byte offset >> 2)
  localparam logic [1:0] SEL_LOW = 2'd0;
  localparam logic [1:0] SEL_MID = 2'd1;
  localparam logic [1:0] SEL_UP  = 2'd2;
  localparam logic [1:0] SEL_INC = 2'd3;

  typedef struct packed {
    logic             wrLow;
    logic             wrMid;
    logic             wrUpper;
    logic             wrInc;
    logic [BUS_W-1:0] data;
  } ncoStrobe_t;

endpackage

// File: rtl/nco_time_datapath.sv
module nco_time_datapath
  import nco_time_pkg::*;
#(
  parameter int               NS_W      = 44,
  parameter int               FRAC_W    = 28,
  parameter logic [BUS_W-1:0] INC_RESET = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoStrobe_t       strobe,
  output logic [NS_W-1:0]  nsTime,
  output logic [BUS_W-1:0] incValue
);

  localparam int ACC_W   = NS_W + FRAC_W;
  localparam int UP_W    = NS_W - LOW_W - MID_W;
  localparam int LOW_LSB = FRAC_W;
  localparam int MID_LSB = FRAC_W + LOW_W;
  localparam int UP_LSB  = MID_LSB + MID_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [BUS_W-1:0] incReg;
  logic             timeWr;

  assign timeWr = strobe.wrLow | strobe.wrMid | strobe.wrUpper;

  always_comb begin
    if (timeWr) begin
      accNext = acc;
      if (strobe.wrLow) begin
        accNext[MID_LSB-1:LOW_LSB] = strobe.data[LOW_W-1:0];
        accNext[FRAC_W-1:0]        = '0;
      end
      if (strobe.wrMid)
        accNext[UP_LSB-1:MID_LSB] = strobe.data[MID_W-1:0];
      if (strobe.wrUpper)
        accNext[ACC_W-1:UP_LSB] = strobe.data[UP_LANE+UP_W-1:UP_LANE];
    end else begin
      accNext = acc + {{(ACC_W-BUS_W){1'b0}}, incReg};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      incReg <= INC_RESET;
    end else begin
      acc <= accNext;
      if (strobe.wrInc) incReg <= strobe.data;
    end
  end

  assign nsTime   = acc[ACC_W-1:FRAC_W];
  assign incValue = incReg;

  // R2: zero increment freezes time
  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rstN)
    (incReg == '0 && !timeWr) |=> $stable(nsTime));

  // R4 / R5: whole-nanosecond increment steps time exactly, modulo 2^NS_W
  assert_int_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!timeWr && incReg[FRAC_W-1:0] == '0) |=>
      nsTime == $past(nsTime) + NS_W'($past(incReg) >> FRAC_W));

  // R3: top field is loaded from the upper write lane
  assert_upper_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrUpper |=> nsTime[NS_W-1:UP_LSB-FRAC_W] == $past(strobe.data[UP_LANE+UP_W-1:UP_LANE]));

  // R7: low write clears the fraction
  assert_low_clears_frac_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLow |=> acc[FRAC_W-1:0] == '0);

  // R9: a middle write lands unchanged, no accumulate on top
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMid |=> nsTime[UP_LSB-FRAC_W-1:MID_LSB-FRAC_W] == $past(strobe.data[MID_W-1:0]));

endmodule

// File: rtl/nco_time_ctrl.sv
module nco_time_ctrl
  import nco_time_pkg::*;
#(
  parameter int NS_W   = 44,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic [NS_W-1:0]   nsTime,
  input  logic [BUS_W-1:0]  incValue,
  output ncoStrobe_t        strobe,
  output logic [BUS_W-1:0]  busRdData,
  output logic              busRdValid
);

  localparam int UP_W    = NS_W - LOW_W - MID_W;
  localparam int SEL_LSB = 2;

  logic [1:0]       wordSel;
  logic             unusedAddrBits;
  logic [MID_W-1:0] shadowMid;
  logic [LOW_W-1:0] shadowLow;
  logic             shadowHeld;
  logic [BUS_W-1:0] rdNext;
  logic             rdUpper;
  logic             rdMid;

  assign wordSel        = busAddr[SEL_LSB+1:SEL_LSB];
  assign unusedAddrBits = ^busAddr[SEL_LSB-1:0];
  assign rdUpper        = busRdEn && (wordSel == SEL_UP);
  assign rdMid          = busRdEn && (wordSel == SEL_MID);

  always_comb begin
    strobe.wrLow   = busWrEn && (wordSel == SEL_LOW);
    strobe.wrMid   = busWrEn && (wordSel == SEL_MID);
    strobe.wrUpper = busWrEn && (wordSel == SEL_UP);
    strobe.wrInc   = busWrEn && (wordSel == SEL_INC);
    strobe.data    = busWrData;
  end

  always_comb begin
    unique case (wordSel)
      SEL_LOW: rdNext = {{(BUS_W-LOW_W){1'b0}},
                         shadowHeld ? shadowLow : nsTime[LOW_W-1:0]};
      SEL_MID: rdNext = shadowHeld ? shadowMid : nsTime[LOW_W+MID_W-1:LOW_W];
      SEL_UP:  rdNext = {{(BUS_W-UP_W){1'b0}}, nsTime[NS_W-1:LOW_W+MID_W]};
      default: rdNext = incValue;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
      shadowMid  <= '0;
      shadowLow  <= '0;
      shadowHeld <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdData <= rdNext;
      if (rdUpper) begin
        shadowMid  <= nsTime[LOW_W+MID_W-1:LOW_W];
        shadowLow  <= nsTime[LOW_W-1:0];
        shadowHeld <= 1'b1;
      end else if (rdMid) begin
        shadowHeld <= 1'b0;
      end
    end
  end

  // R11: one response per request, one cycle later
  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  assert_no_spurious_rd_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);

  // R8: top-byte read followed directly by a middle read returns the earlier time
  assert_coherent_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdUpper ##1 rdMid |=> busRdData == $past(nsTime[LOW_W+MID_W-1:LOW_W], 2));

endmodule

// File: rtl/nco_time_counter.sv
module nco_time_counter
  import nco_time_pkg::*;
#(
  parameter int               NS_W      = 44,
  parameter int               FRAC_W    = 28,
  parameter int               ADDR_W    = 4,
  parameter logic [31:0]      INC_RESET = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdValid
);

  ncoStrobe_t       strobe;
  logic [NS_W-1:0]  nsTime;
  logic [BUS_W-1:0] incValue;

  nco_time_ctrl #(.NS_W(NS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .nsTime     (nsTime),
    .incValue   (incValue),
    .strobe     (strobe),
    .busRdData  (busRdData),
    .busRdValid (busRdValid)
  );

  nco_time_datapath #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_RESET(INC_RESET)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .nsTime   (nsTime),
    .incValue (incValue)
  );

endmodule

// File: tb/nco_time_counter_test.sv
`timescale 1ns/1ps
module nco_time_counter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  nco_time_counter uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid)
  );

  // monitor: pop expected items as responses arrive
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response actual=%h expected=none", busRdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (busRdData !== it.val) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, busRdData, it.val);
        end
      end
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.val = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic writeTime(input logic [43:0] t);
    busWrite(4'h8, {16'h0, t[43:36], 8'h5A});
    busWrite(4'h4, t[35:4]);
    busWrite(4'h0, {28'hABCDEF0, t[3:0]});
  endtask

  task automatic checkTime(input logic [43:0] t, input string tag);
    busRead(4'h8, {24'h0, t[43:36]}, tag);
    busRead(4'h0, {28'h0, t[3:0]}, tag);
    busRead(4'h4, t[35:4], tag);
  endtask

  // increment active for k+1 accumulate edges, then frozen
  task automatic runFor(input logic [31:0] inc, input int k);
    busWrite(4'hC, inc);
    repeat (k) @(posedge clk);
    busWrite(4'hC, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [43:0] t;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (busRdValid !== 1'b0 || busRdData !== 32'h0) begin
      errors++;
      $display("FAIL R1 actual=%b/%h expected=0/00000000", busRdValid, busRdData);
    end
    busRead(4'hC, 32'h8000_0000, "R1 reset increment");

    // freeze and load
    busWrite(4'hC, 32'h0);
    t = 44'h7FF_FFFF_FFC0;
    writeTime(t);
    checkTime(t, "R3 top byte via lane [15:8]");
    repeat (20) @(posedge clk);
    checkTime(t, "R2 frozen time");

    // R4: nominal rate, 10 accumulates -> +80 ns, crossing into top byte
    runFor(32'h8000_0000, 9);
    checkTime(t + 44'd80, "R4 nominal 8 ns per cycle");

    // R5: wrap at 2^44
    t = 44'hFFF_FFFF_FFF0;
    writeTime(t);
    runFor(32'h8000_0000, 3);
    checkTime(44'd16, "R5 wrap modulo 2^44");

    // R6: half-nanosecond increment, 5 accumulates -> +2.5 ns
    writeTime(44'd100);
    runFor(32'h0800_0000, 4);
    checkTime(44'd102, "R6 fractional accumulate");

    // R7: rewriting low clears the leftover half ns
    busWrite(4'h0, 32'h6);
    runFor(32'h0800_0000, 0);
    checkTime(44'd102, "R7 low write clears fraction");

    // R8: coherent pair while running
    t = 44'h123_4567_89A8;
    writeTime(t);
    busWrite(4'hC, 32'h8000_0000);
    busRead(4'h8, 32'h12, "R8 top byte at capture");
    repeat (5) @(posedge clk);
    busRead(4'h0, {28'h0, t[3:0]}, "R8 low from capture");
    busRead(4'h4, t[35:4], "R8 middle from capture");
    busWrite(4'hC, 32'h0);
    checkTime(t + 44'd72, "R8 live time after capture ends");

    // R9: time write replaces that cycle's accumulate
    t = 44'h0F0_0000_0003;
    writeTime(t);
    busWrite(4'hC, 32'h8000_0000);
    busWrite(4'h4, 32'h1111_1111);
    busWrite(4'hC, 32'h0);
    checkTime({8'h0F, 32'h1111_1111, 4'h3} + 44'd8, "R9 write wins over accumulate");

    // R10: full-word readback and all-zero idle
    busWrite(4'h4, 32'hDEAD_BEEF);
    busRead(4'h4, 32'hDEAD_BEEF, "R10 middle readback");
    busWrite(4'hC, 32'h1234_5678);
    busRead(4'hC, 32'h1234_5678, "R10 increment readback");
    busWrite(4'hC, 32'h0);
    busWrite(4'h0, 32'h0);
    busWrite(4'h4, 32'h0);
    busWrite(4'h8, 32'h0);
    repeat (3) @(posedge clk);
    busRead(4'h8, 32'h0, "R10 idle top");
    busRead(4'h0, 32'h0, "R10 idle low");
    busRead(4'h4, 32'h0, "R10 idle middle");
    busRead(4'hC, 32'h0, "R10 idle increment");

    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (expQ.size() != 0 || busRdValid !== 1'b0) begin
      errors++;
      $display("FAIL R11 pending=%0d valid=%b expected=0/0", expQ.size(), busRdValid);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule